// File: doc/BRIEF.md
# NAND Flash Operation Sequencer

This block runs one raw operation on an 8-bit NAND flash bus. Software first loads four setup registers: a command word holding two opcodes, a 64-bit address made of a low and a high half, and a byte count. It then writes an operation word. Each enable bit in that word switches on one phase of the operation. The phases are a first command byte, a run of address bytes, a stream of write-data bytes, a second command byte, a wait for the device to go ready, and a run of read-data bytes. The engine always runs the enabled phases in that order and skips the rest. It drives the latch enables, the write and read strobes, the data bus and one of four chip enables, and it watches the ready/busy line.

Write data comes in on a valid/ready byte stream. A byte moves when `wdat_valid` and `wdat_ready` are both high at a clock edge. `wdat_ready` is high only during the write-data phase and only while no byte is on the bus. When the source holds `wdat_valid` low, the engine waits with WE# high for as long as needed and loses nothing. `wdat_valid` has no effect outside the write-data phase. Read bytes go into a small local buffer, which can be read at any time through a combinational index port. Strobe widths are programmable: one count sets the WE# low time, another sets the RE# low time, and a shared count sets the high time.

Top module: `nand_op_seq`

## Requirements
- R1: After reset, `ready` is 1, all `nand_ce_n` are 1, `nand_we_n` and `nand_re_n` are 1, `nand_cle`, `nand_ale` and `nand_io_oe` are 0, and the timing register holds WE# low 5, RE# low 7 and high 3 clocks.
- R2: A write to the operation register (`cfg_sel`=5) while `ready`=1 starts an operation, and `ready` reads 0 from the next clock. While `ready`=0, writes to any register (`cfg_sel` 0 command, 1 address low, 2 address high, 3 count, 4 timing, 5 operation) have no effect.
- R3: In the operation word, bit6 enables the first command, bit5 the address, bit4 the write data, bit3 the second command, bit2 the wait for ready and bit1 the read data. Enabled phases run in that order. An address phase with zero cycles, or a data phase with a count of 0, counts as disabled. A word that enables no phase leaves `ready` at 1.
- R4: A command phase puts one byte on `nand_io_out` with `nand_cle`=1 and `nand_io_oe`=1: command bits 7:0 for the first command and bits 15:8 for the second. The byte is latched by one WE# pulse.
- R5: The address phase drives `nand_ale`=1 and sends as many bytes as operation bits 11:9 give. The bytes come from {address high, address low}, least significant byte first.
- R6: In the timing register, bits 3:0 set the WE# low clocks, bits 7:4 the RE# low clocks and bits 11:8 the high clocks after each pulse. A value of 0 acts as 1. Within a phase, consecutive pulses are separated by the high count plus one clock.
- R7: While an operation runs, only the chip enable chosen by operation bits 8:7 is low. The others stay high, and all are high when idle.
- R8: Each write-data byte is taken from the stream on a valid/ready handshake and sent with one WE# pulse. While `wdat_valid` is low, no WE# pulse occurs and the operation stays busy.
- R9: The wait phase ignores `nand_rb_n` for 8 clocks. It then ends only after `nand_rb_n` has been sampled high on two consecutive clocks, so with the line already high it adds exactly 10 clocks.
- R10: Read byte k is sampled from `nand_io_in` on the clock edge that ends its RE# low time and is stored at buffer index k. Bytes at an index of 16 (the buffer depth) or more are dropped.
- R11: `nand_cle` and `nand_ale` are never high together. WE# and RE# are never low together, and RE# is never low while the bus is driven.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_we | input | 1 | Register write strobe |
| cfg_sel | input | 3 | Register select (0 cmd, 1 addr low, 2 addr high, 3 count, 4 timing, 5 operation) |
| cfg_wdata | input | 32 | Register write data |
| ready | output | 1 | 1 when idle, 0 while an operation runs |
| wdat_valid | input | 1 | Write-data stream valid |
| wdat_ready | output | 1 | Write-data stream ready |
| wdat_byte | input | 8 | Write-data stream byte |
| rbuf_idx | input | log2(BUF_DEPTH) | Read buffer index |
| rbuf_byte | output | 8 | Read buffer byte at `rbuf_idx` |
| nand_ce_n | output | 4 | Chip enables, active low |
| nand_cle | output | 1 | Command latch enable |
| nand_ale | output | 1 | Address latch enable |
| nand_we_n | output | 1 | Write strobe, active low |
| nand_re_n | output | 1 | Read strobe, active low |
| nand_io_out | output | 8 | Bus byte driven to the device |
| nand_io_oe | output | 1 | Bus output enable |
| nand_io_in | input | 8 | Bus byte from the device |
| nand_rb_n | input | 1 | Ready/busy from the device, low while busy |

## Verification
The assertions assume that `nand_rb_n` and `wdat_valid` are already synchronous to `clk` and change only away from the active edge. They also assume that register writes are plain single-cycle strobes. The start check further assumes that an operation word with a command or wait bit set always leads to a busy period. The bench meets these assumptions by driving every input on the falling clock edge, by keeping each write strobe high for exactly one cycle, and by releasing ready/busy only in whole clock cycles. The single-cycle ready glitch therefore lands cleanly on one sampling edge.

// File: rtl/nand_seq_pkg.sv
package nand_seq_pkg;

  localparam int NUM_CE = 4;

  localparam logic [3:0] RST_WLOW = 4'd5;
  localparam logic [3:0] RST_RLOW = 4'd7;
  localparam logic [3:0] RST_HIGH = 4'd3;

  typedef enum logic [2:0] {
    REG_CMD     = 3'd0,
    REG_ADDR_LO = 3'd1,
    REG_ADDR_HI = 3'd2,
    REG_COUNT   = 3'd3,
    REG_PWIDTH  = 3'd4,
    REG_OP      = 3'd5
  } reg_sel_e;

  // numeric order is the execution order of the phases
  typedef enum logic [2:0] {
    PH_IDLE   = 3'd0,
    PH_CMD1   = 3'd1,
    PH_ADDR   = 3'd2,
    PH_WDATA  = 3'd3,
    PH_CMD2   = 3'd4,
    PH_TWB    = 3'd5,
    PH_WAITRB = 3'd6,
    PH_RDATA  = 3'd7
  } phase_e;

  // operation word bits 11:1, packed msb first
  typedef struct packed {
    logic [2:0] acyc;
    logic [1:0] cs;
    logic       c1;
    logic       ad;
    logic       wr;
    logic       c2;
    logic       wt;
    logic       rd;
  } op_t;

  function automatic phase_e next_phase(input phase_e cur, input op_t op,
                                        input logic cnt_nz);
    logic [7:0] en;
    phase_e     nxt;
    en            = '0;
    en[PH_CMD1]   = op.c1;
    en[PH_ADDR]   = op.ad && (op.acyc != 3'd0);
    en[PH_WDATA]  = op.wr && cnt_nz;
    en[PH_CMD2]   = op.c2;
    en[PH_TWB]    = op.wt;
    en[PH_RDATA]  = op.rd && cnt_nz;
    nxt = PH_IDLE;
    for (int k = 7; k >= 1; k--) begin
      if ((k > int'(cur)) && en[k]) nxt = phase_e'(k);
    end
    return nxt;
  endfunction

endpackage

// File: rtl/nand_seq_regs.sv
module nand_seq_regs
  import nand_seq_pkg::*;
#(
  parameter int CNT_W = 12
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             we,
  input  logic [2:0]       sel,
  input  logic [31:0]      wdata,
  input  logic             idle,
  output logic [15:0]      cmd_q,
  output logic [63:0]      addr_q,
  output logic [CNT_W-1:0] cnt_q,
  output logic [3:0]       wlow_q,
  output logic [3:0]       rlow_q,
  output logic [3:0]       high_q,
  output logic             op_go,
  output op_t              op_word
);

  logic wr_ok;
  assign wr_ok   = we && idle;
  assign op_go   = wr_ok && (sel == REG_OP);
  assign op_word = op_t'(wdata[11:1]);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cmd_q  <= '0;
      addr_q <= '0;
      cnt_q  <= '0;
      wlow_q <= RST_WLOW;
      rlow_q <= RST_RLOW;
      high_q <= RST_HIGH;
    end else if (wr_ok) begin
      case (sel)
        REG_CMD:     cmd_q          <= wdata[15:0];
        REG_ADDR_LO: addr_q[31:0]   <= wdata;
        REG_ADDR_HI: addr_q[63:32]  <= wdata;
        REG_COUNT:   cnt_q          <= wdata[CNT_W-1:0];
        REG_PWIDTH: begin
          wlow_q <= wdata[3:0];
          rlow_q <= wdata[7:4];
          high_q <= wdata[11:8];
        end
        default: ;
      endcase
    end
  end

endmodule

// File: rtl/nand_seq_strobe.sv
module nand_seq_strobe #(
  parameter int W = 4
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         start,
  input  logic [W-1:0] low_len,
  input  logic [W-1:0] high_len,
  output logic         low_o,
  output logic         sample_o,
  output logic         done_o
);

  typedef enum logic [1:0] {ST_IDLE, ST_LOW, ST_HIGH} st_e;

  st_e          st_q;
  logic [W-1:0] cnt_q;
  logic [W-1:0] low_ld, high_ld;

  // a programmed zero behaves as one clock
  assign low_ld  = (low_len  == '0) ? '0 : low_len  - W'(1);
  assign high_ld = (high_len == '0) ? '0 : high_len - W'(1);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q  <= ST_IDLE;
      cnt_q <= '0;
    end else begin
      case (st_q)
        ST_IDLE: if (start) begin
          st_q  <= ST_LOW;
          cnt_q <= low_ld;
        end
        ST_LOW: if (cnt_q == '0) begin
          st_q  <= ST_HIGH;
          cnt_q <= high_ld;
        end else begin
          cnt_q <= cnt_q - W'(1);
        end
        ST_HIGH: if (cnt_q == '0) begin
          st_q <= ST_IDLE;
        end else begin
          cnt_q <= cnt_q - W'(1);
        end
        default: st_q <= ST_IDLE;
      endcase
    end
  end

  assign low_o    = (st_q == ST_LOW);
  assign sample_o = (st_q == ST_LOW)  && (cnt_q == '0);
  assign done_o   = (st_q == ST_HIGH) && (cnt_q == '0);

endmodule

// File: rtl/nand_seq_rbuf.sv
module nand_seq_rbuf #(
  parameter int DEPTH = 16,
  parameter int CNT_W = 12,
  localparam int IW   = $clog2(DEPTH)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr_en,
  input  logic [CNT_W-1:0] wr_idx,
  input  logic [7:0]       wr_byte,
  input  logic [IW-1:0]    rd_idx,
  output logic [7:0]       rd_byte
);

  logic [7:0] mem [DEPTH];
  logic       in_range;

  assign in_range = (wr_idx < CNT_W'(DEPTH));

  for (genvar g = 0; g < DEPTH; g++) begin : g_ent
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        mem[g] <= '0;
      end else if (wr_en && in_range && (wr_idx[IW-1:0] == IW'(g))) begin
        mem[g] <= wr_byte;
      end
    end
  end

  assign rd_byte = mem[rd_idx];

endmodule

// File: rtl/nand_op_seq.sv
module nand_op_seq
  import nand_seq_pkg::*;
#(
  parameter int CNT_W     = 12,
  parameter int BUF_DEPTH = 16,
  parameter int TWB_CYC   = 8,
  localparam int BUF_IW   = $clog2(BUF_DEPTH),
  localparam int TWB_W    = $clog2(TWB_CYC + 1)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cfg_we,
  input  logic [2:0]        cfg_sel,
  input  logic [31:0]       cfg_wdata,
  output logic              ready,
  input  logic              wdat_valid,
  output logic              wdat_ready,
  input  logic [7:0]        wdat_byte,
  input  logic [BUF_IW-1:0] rbuf_idx,
  output logic [7:0]        rbuf_byte,
  output logic [NUM_CE-1:0] nand_ce_n,
  output logic              nand_cle,
  output logic              nand_ale,
  output logic              nand_we_n,
  output logic              nand_re_n,
  output logic [7:0]        nand_io_out,
  output logic              nand_io_oe,
  input  logic [7:0]        nand_io_in,
  input  logic              nand_rb_n
);

  logic [15:0]      cmd_q;
  logic [63:0]      addr_q;
  logic [CNT_W-1:0] cnt_q;
  logic [3:0]       wlow_q, rlow_q, high_q;
  logic             op_go;
  op_t              op_word;

  phase_e           phase_q;
  op_t              op_q;
  logic             byte_act_q;
  logic [CNT_W-1:0] idx_q;
  logic [7:0]       io_q;
  logic [TWB_W-1:0] wt_q;
  logic             rb_seen_q;

  logic             st_low, st_sample, st_done;
  logic             is_bus, start, last, cnt_nz;
  logic [7:0]       nxt_byte;
  logic [CNT_W-1:0] len;
  phase_e           nxt_after;

  assign ready = (phase_q == PH_IDLE);

  nand_seq_regs #(.CNT_W(CNT_W)) i_regs (
    .clk     (clk),
    .rst_n   (rst_n),
    .we      (cfg_we),
    .sel     (cfg_sel),
    .wdata   (cfg_wdata),
    .idle    (ready),
    .cmd_q   (cmd_q),
    .addr_q  (addr_q),
    .cnt_q   (cnt_q),
    .wlow_q  (wlow_q),
    .rlow_q  (rlow_q),
    .high_q  (high_q),
    .op_go   (op_go),
    .op_word (op_word)
  );

  assign cnt_nz = |cnt_q;
  assign is_bus = (phase_q == PH_CMD1) || (phase_q == PH_ADDR) ||
                  (phase_q == PH_WDATA) || (phase_q == PH_CMD2) ||
                  (phase_q == PH_RDATA);
  assign wdat_ready = (phase_q == PH_WDATA) && !byte_act_q;
  assign start = is_bus && !byte_act_q &&
                 ((phase_q != PH_WDATA) || wdat_valid);

  always_comb begin
    case (phase_q)
      PH_CMD1:  nxt_byte = cmd_q[7:0];
      PH_CMD2:  nxt_byte = cmd_q[15:8];
      PH_ADDR:  nxt_byte = addr_q[{idx_q[2:0], 3'b000} +: 8];
      PH_WDATA: nxt_byte = wdat_byte;
      default:  nxt_byte = 8'h00;
    endcase
    case (phase_q)
      PH_ADDR:            len = CNT_W'(op_q.acyc);
      PH_WDATA, PH_RDATA: len = cnt_q;
      default:            len = CNT_W'(1);
    endcase
  end

  assign last      = (idx_q == len - CNT_W'(1));
  assign nxt_after = next_phase(phase_q, op_q, cnt_nz);

  nand_seq_strobe #(.W(4)) i_strobe (
    .clk      (clk),
    .rst_n    (rst_n),
    .start    (start),
    .low_len  ((phase_q == PH_RDATA) ? rlow_q : wlow_q),
    .high_len (high_q),
    .low_o    (st_low),
    .sample_o (st_sample),
    .done_o   (st_done)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      phase_q    <= PH_IDLE;
      op_q       <= '0;
      byte_act_q <= 1'b0;
      idx_q      <= '0;
      io_q       <= '0;
      wt_q       <= '0;
      rb_seen_q  <= 1'b0;
    end else begin
      case (phase_q)
        PH_IDLE: begin
          byte_act_q <= 1'b0;
          idx_q      <= '0;
          wt_q       <= '0;
          rb_seen_q  <= 1'b0;
          if (op_go) begin
            op_q    <= op_word;
            phase_q <= next_phase(PH_IDLE, op_word, cnt_nz);
          end
        end
        PH_TWB: begin
          if (wt_q == TWB_W'(TWB_CYC - 1)) begin
            phase_q   <= PH_WAITRB;
            rb_seen_q <= 1'b0;
          end else begin
            wt_q <= wt_q + TWB_W'(1);
          end
        end
        PH_WAITRB: begin
          if (nand_rb_n) begin
            if (rb_seen_q) phase_q <= nxt_after;
            rb_seen_q <= 1'b1;
          end else begin
            rb_seen_q <= 1'b0;
          end
        end
        default: begin
          if (start) begin
            byte_act_q <= 1'b1;
            io_q       <= nxt_byte;
          end else if (byte_act_q && st_done) begin
            byte_act_q <= 1'b0;
            if (last) begin
              idx_q   <= '0;
              wt_q    <= '0;
              phase_q <= nxt_after;
            end else begin
              idx_q <= idx_q + CNT_W'(1);
            end
          end
        end
      endcase
    end
  end

  nand_seq_rbuf #(.DEPTH(BUF_DEPTH), .CNT_W(CNT_W)) i_rbuf (
    .clk     (clk),
    .rst_n   (rst_n),
    .wr_en   ((phase_q == PH_RDATA) && st_sample),
    .wr_idx  (idx_q),
    .wr_byte (nand_io_in),
    .rd_idx  (rbuf_idx),
    .rd_byte (rbuf_byte)
  );

  assign nand_ce_n   = ready ? '1 : ~(NUM_CE'(1) << op_q.cs);
  assign nand_cle    = (phase_q == PH_CMD1) || (phase_q == PH_CMD2);
  assign nand_ale    = (phase_q == PH_ADDR);
  assign nand_io_oe  = nand_cle || nand_ale || (phase_q == PH_WDATA);
  assign nand_io_out = io_q;
  assign nand_we_n   = !(st_low && (phase_q != PH_RDATA));
  assign nand_re_n   = !(st_low && (phase_q == PH_RDATA));

endmodule

// File: rtl/nand_op_seq_chk.sv
module nand_op_seq_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       cfg_we,
  input logic [2:0] cfg_sel,
  input logic [5:0] op_en,
  input logic       ready,
  input logic       wdat_ready,
  input logic [3:0] ce_n,
  input logic       cle,
  input logic       ale,
  input logic       we_n,
  input logic       re_n,
  input logic       io_oe
);

  // R7: at most one device selected at a time
  p_ce_onehot_r7: assert property (@(posedge clk) disable iff (!rst_n)
    $countones(~ce_n) <= 1);

  // R7: no device selected while idle
  p_idle_ce_r7: assert property (@(posedge clk) disable iff (!rst_n)
    ready |-> (ce_n == 4'hF));

  // R11: latch enables are exclusive
  p_cle_ale_excl_r11: assert property (@(posedge clk) disable iff (!rst_n)
    !(cle && ale));

  // R11: strobes are exclusive
  p_we_re_excl_r11: assert property (@(posedge clk) disable iff (!rst_n)
    !(!we_n && !re_n));

  // R11: no read strobe while the bus is driven
  p_oe_no_re_r11: assert property (@(posedge clk) disable iff (!rst_n)
    io_oe |-> re_n);

  // R2: an accepted operation with a command or wait phase clears ready
  p_start_busy_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (cfg_we && (cfg_sel == 3'd5) && ready && (op_en[5] || op_en[2] || op_en[1]))
      |=> !ready);

  // R8: the stream is only accepted during an operation
  p_wready_busy_r8: assert property (@(posedge clk) disable iff (!rst_n)
    wdat_ready |-> !ready);

endmodule

bind nand_op_seq nand_op_seq_chk i_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .cfg_we     (cfg_we),
  .cfg_sel    (cfg_sel),
  .op_en      (cfg_wdata[6:1]),
  .ready      (ready),
  .wdat_ready (wdat_ready),
  .ce_n       (nand_ce_n),
  .cle        (nand_cle),
  .ale        (nand_ale),
  .we_n       (nand_we_n),
  .re_n       (nand_re_n),
  .io_oe      (nand_io_oe)
);

// File: tb/test_nand_op_seq.sv
`timescale 1ns/1ps
module test_nand_op_seq;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        cfg_we = 1'b0;
  logic [2:0]  cfg_sel = 3'd0;
  logic [31:0] cfg_wdata = 32'd0;
  logic        ready;
  logic        wdat_valid = 1'b1;
  logic        wdat_ready;
  logic [7:0]  wdat_byte;
  logic [3:0]  rbuf_idx = 4'd0;
  logic [7:0]  rbuf_byte;
  logic [3:0]  nand_ce_n;
  logic        nand_cle, nand_ale, nand_we_n, nand_re_n, nand_io_oe;
  logic [7:0]  nand_io_out, nand_io_in;
  logic        nand_rb_n = 1'b1;

  int checks = 0;
  int fails  = 0;

  // monitor state
  logic       mon_clr = 1'b0;
  logic       prev_we = 1'b1, prev_re = 1'b1;
  int         we_edges = 0, re_rises = 0, excl_bad = 0;
  int         we_run = 0, re_run = 0, gap_run = 0;
  int         last_we_low = 0, last_re_low = 0, last_gap = 0;
  logic [3:0] last_ce = 4'hF;
  logic [7:0] wlog [32];
  logic [7:0] wcnt = 8'd0;

  always #10 clk = ~clk;

  assign wdat_byte  = 8'hA0 + wcnt;
  assign nand_io_in = 8'h40 + 8'(re_rises);

  nand_op_seq i_nand_op_seq (
    .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_sel(cfg_sel),
    .cfg_wdata(cfg_wdata), .ready(ready), .wdat_valid(wdat_valid),
    .wdat_ready(wdat_ready), .wdat_byte(wdat_byte), .rbuf_idx(rbuf_idx),
    .rbuf_byte(rbuf_byte), .nand_ce_n(nand_ce_n), .nand_cle(nand_cle),
    .nand_ale(nand_ale), .nand_we_n(nand_we_n), .nand_re_n(nand_re_n),
    .nand_io_out(nand_io_out), .nand_io_oe(nand_io_oe),
    .nand_io_in(nand_io_in), .nand_rb_n(nand_rb_n)
  );

  always @(posedge clk) begin
    if (mon_clr) wcnt <= 8'd0;
    else if (wdat_valid && wdat_ready) wcnt <= wcnt + 8'd1;
  end

  always @(negedge clk) begin
    if ((nand_cle && nand_ale) || (!nand_we_n && !nand_re_n)) excl_bad++;
    if (mon_clr) begin
      we_edges = 0;
      re_rises = 0;
    end else begin
      if (!nand_we_n) begin
        if (prev_we) last_gap = gap_run;
        we_run++;
        gap_run = 0;
      end else begin
        gap_run++;
        if (!prev_we) begin
          last_we_low = we_run;
          we_run = 0;
          if (we_edges < 32) wlog[we_edges] = nand_io_out;
          last_ce = nand_ce_n;
          we_edges++;
        end
      end
      if (!nand_re_n) re_run++;
      else if (!prev_re) begin
        last_re_low = re_run;
        re_run = 0;
        re_rises++;
      end
    end
    prev_we = nand_we_n;
    prev_re = nand_re_n;
  end

  task automatic chk(input bit ok, input string req, input string what,
                     input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s: actual=0x%0h expected=0x%0h", req, what, act, exp);
    end
  endtask

  task automatic cfg_write(input logic [2:0] sel, input logic [31:0] d);
    @(negedge clk);
    cfg_we = 1'b1; cfg_sel = sel; cfg_wdata = d;
    @(negedge clk);
    cfg_we = 1'b0;
  endtask

  // clears the monitor and writes the operation word
  task automatic start_op(input logic [11:0] op);
    @(negedge clk);
    mon_clr = 1'b1;
    @(negedge clk);
    cfg_we = 1'b1; cfg_sel = 3'd5; cfg_wdata = {20'd0, op};
    @(negedge clk);
    cfg_we = 1'b0; mon_clr = 1'b0;
  endtask

  task automatic wait_idle(output int n);
    n = 0;
    while (!ready && n < 5000) begin
      n++;
      @(negedge clk);
    end
  endtask

  task automatic setup(input logic [15:0] cmd, input logic [31:0] lo,
                       input logic [11:0] cnt);
    cfg_write(3'd0, {16'd0, cmd});
    cfg_write(3'd1, lo);
    cfg_write(3'd2, 32'd0);
    cfg_write(3'd3, {20'd0, cnt});
  endtask

  task automatic rbuf_at(input logic [3:0] i, output logic [7:0] b);
    @(negedge clk);
    rbuf_idx = i;
    #1;
    b = rbuf_byte;
  endtask

  // cmd16 | addr_lo32 | op12 | cnt12 | nwe8 | first8 | last8 | nre8 | ce4
  localparam int NV = 6;
  localparam logic [107:0] VEC [NV] = '{
    {16'hD060, 32'h00123456, 12'h6EC, 12'd0,  8'd5, 8'h60, 8'hD0, 8'd0,  4'b1101},
    {16'h0090, 32'h00000000, 12'h262, 12'd16, 8'd2, 8'h90, 8'h00, 8'd16, 4'b1110},
    {16'h00FF, 32'h00000000, 12'h1C4, 12'd0,  8'd1, 8'hFF, 8'hFF, 8'd0,  4'b0111},
    {16'h1080, 32'h00000201, 12'h578, 12'd3,  8'd7, 8'h80, 8'h10, 8'd0,  4'b1011},
    {16'h0070, 32'h00000000, 12'h042, 12'd1,  8'd1, 8'h70, 8'h70, 8'd1,  4'b1110},
    {16'h3000, 32'h00000000, 12'h008, 12'd0,  8'd1, 8'h30, 8'h30, 8'd0,  4'b1110}
  };

  initial begin
    #(20 * 150000);
    fails++;
    $display("FAIL watchdog: actual=running expected=done");
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    int n;
    logic [7:0] b;
    repeat (3) @(negedge clk);
    // R1 reset state
    chk(ready == 1'b1, "R1", "ready", int'(ready), 1);
    chk(nand_ce_n == 4'hF, "R1", "ce_n", int'(nand_ce_n), 15);
    chk({nand_we_n, nand_re_n, nand_cle, nand_ale, nand_io_oe} == 5'b11000,
        "R1", "bus idle", int'({nand_we_n, nand_re_n, nand_cle, nand_ale, nand_io_oe}), 24);
    rst_n = 1'b1;
    repeat (2) @(negedge clk);

    // vector walk: R3 R4 R5 R7 R8 R10
    for (int i = 0; i < NV; i++) begin
      setup(VEC[i][107:92], VEC[i][91:60], VEC[i][47:36]);
      start_op(VEC[i][59:48]);
      wait_idle(n);
      chk(n < 5000, "R3", $sformatf("vec%0d finished", i), n, 0);
      chk(we_edges == int'(VEC[i][35:28]), "R4", $sformatf("vec%0d WE pulses", i),
          we_edges, int'(VEC[i][35:28]));
      chk(wlog[0] == VEC[i][27:20], "R3", $sformatf("vec%0d first byte", i),
          int'(wlog[0]), int'(VEC[i][27:20]));
      chk(wlog[we_edges-1] == VEC[i][19:12], "R4", $sformatf("vec%0d last byte", i),
          int'(wlog[we_edges-1]), int'(VEC[i][19:12]));
      chk(re_rises == int'(VEC[i][11:4]), "R10", $sformatf("vec%0d RE pulses", i),
          re_rises, int'(VEC[i][11:4]));
      chk(last_ce == VEC[i][3:0], "R7", $sformatf("vec%0d ce_n", i),
          int'(last_ce), int'(VEC[i][3:0]));
      if (i == 0) begin
        chk(wlog[1] == 8'h56 && wlog[3] == 8'h12, "R5", "address LSB first",
            int'({wlog[1], wlog[3]}), 16'h5612);
        chk(last_we_low == 5, "R6", "default WE low", last_we_low, 5);
      end
      if (i == 1) begin
        chk(last_re_low == 7, "R6", "default RE low", last_re_low, 7);
        rbuf_at(4'd5, b);
        chk(b == 8'h45, "R10", "buffer index 5", int'(b), 8'h45);
      end
      if (i == 3) begin
        chk(wlog[1] == 8'h01 && wlog[2] == 8'h02 && wlog[3] == 8'hA0 && wlog[5] == 8'hA2,
            "R8", "address then data order", int'({wlog[1], wlog[3], wlog[5]}), 24'h01A0A2);
      end
    end

    // R6 programmed widths
    cfg_write(3'd4, 32'h142);
    setup(16'h0000, 32'h0000_0000, 12'd1);
    start_op(12'h460);
    wait_idle(n);
    chk(last_we_low == 2, "R6", "WE low 2", last_we_low, 2);
    chk(last_gap == 2, "R6", "gap high+1", last_gap, 2);
    start_op(12'h042);
    wait_idle(n);
    chk(last_re_low == 4, "R6", "RE low 4", last_re_low, 4);
    cfg_write(3'd4, 32'h000);
    start_op(12'h040);
    wait_idle(n);
    chk(last_we_low == 1, "R6", "zero acts as one", last_we_low, 1);
    cfg_write(3'd4, 32'h375);

    // R9 exact wait length with ready already high
    setup(16'h00FF, 32'd0, 12'd0);
    start_op(12'h044);
    wait_idle(n);
    chk(n == 19, "R9", "busy cycles", n, 19);

    // R9 glitch and R2 ignore while busy
    nand_rb_n = 1'b0;
    start_op(12'h044);
    repeat (30) @(negedge clk);
    chk(ready == 1'b0, "R9", "held by busy line", int'(ready), 0);
    cfg_write(3'd0, 32'h0000_00AA);
    cfg_write(3'd5, 32'h0000_0040);
    @(negedge clk); nand_rb_n = 1'b1;
    @(negedge clk); nand_rb_n = 1'b0;
    repeat (5) @(negedge clk);
    chk(ready == 1'b0, "R9", "single high sample ignored", int'(ready), 0);
    nand_rb_n = 1'b1;
    wait_idle(n);
    chk(we_edges == 1, "R2", "busy op write ignored", we_edges, 1);
    start_op(12'h040);
    wait_idle(n);
    chk(wlog[0] == 8'hFF, "R2", "busy cmd write ignored", int'(wlog[0]), 8'hFF);

    // R8 stream stall
    wdat_valid = 1'b0;
    setup(16'h1080, 32'h0000_0201, 12'd2);
    start_op(12'h578);
    repeat (60) @(negedge clk);
    chk(ready == 1'b0 && we_edges == 3, "R8", "stalled WE pulses", we_edges, 3);
    wdat_valid = 1'b1;
    wait_idle(n);
    chk(we_edges == 6, "R8", "pulses after release", we_edges, 6);
    chk(wlog[3] == 8'hA0 && wlog[4] == 8'hA1, "R8", "stream bytes",
        int'({wlog[3], wlog[4]}), 16'hA0A1);

    // R10 beyond buffer depth
    setup(16'h0090, 32'd0, 12'd20);
    start_op(12'h042);
    wait_idle(n);
    chk(re_rises == 20, "R10", "RE pulses", re_rises, 20);
    rbuf_at(4'd0, b);
    chk(b == 8'h40, "R10", "buffer index 0", int'(b), 8'h40);
    rbuf_at(4'd15, b);
    chk(b == 8'h4F, "R10", "extra bytes dropped", int'(b), 8'h4F);

    // R3 empty operation words
    start_op(12'h000);
    chk(ready == 1'b1 && we_edges == 0, "R3", "empty op stays ready", int'(ready), 1);
    start_op(12'h020);
    chk(ready == 1'b1, "R3", "zero address cycles skipped", int'(ready), 1);

    // R11 bus exclusivity across the whole run
    chk(excl_bad == 0, "R11", "exclusive controls", excl_bad, 0);

    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

endmodule